// File: doc/BRIEF.md
# Serial Wire Debug Host Transfer Engine

This block is the host side of a two-wire serial debug link. It takes one command, runs one complete packet on the wire and returns the result. A command names the port class (debug port or access port), the direction, a 2-bit register index and, for writes, a 32-bit word. The engine divides the system clock to make the serial clock. It sends the 8-bit request, turns the data line around, collects the 3-bit target acknowledge and then moves the data word and its even parity in the right direction. The bidirectional data pin is modelled as separate output, output-enable and input signals.

Commands come in on a valid/ready port. `cmd_ready` is high only while the engine is idle. A command is taken on the clock edge where `cmd_valid` and `cmd_ready` are both high, and its fields are copied at that edge. Results go out on a valid/ready port. `rsp_valid` stays high, with its fields frozen, until `rsp_ready` is seen. No new command is taken before then, so a slow consumer stalls the link and no result is lost. Retrying after a WAIT and resetting the line are the caller's job.

Top module: `swd_host_engine`

## Requirements
- R1: A command is taken only on an edge with `cmd_valid` and `cmd_ready` both high. `cmd_ready` is low from that edge until the result has been consumed. A `cmd_valid` seen while busy has no effect on the running packet.
- R2: `swclk` is low whenever the engine is not busy. During a packet it toggles every `CLK_DIV` system clocks, so one period is 2*`CLK_DIV` system clocks.
- R3: The request goes out on the first 8 rising edges, first bit first, in this order: 1, port select (1 = access port), direction (1 = read), index bit 0, index bit 1, the XOR of the four bits before it, 0, then 1.
- R4: Every bit the host drives changes only on a falling `swclk` edge. Between packets the engine drives the line low (`swdio_oe`=1, `swdio_o`=0).
- R5: `swdio_oe` drops at the falling edge that ends the last request bit. The three acknowledge bits are sampled on the next three falling edges, first bit into `rsp_ack[0]`. Codes: 001 OK, 010 WAIT, 100 FAULT, 111 no answer; any other code is a protocol error.
- R6: On a write, after the last acknowledge sample the host keeps the line released for one more full clock period. It then drives the 32 data bits, lowest first, followed by their even parity bit, one per period.
- R7: The write data phase is sent for OK, WAIT and FAULT. It is skipped for no-answer and for protocol-error codes.
- R8: On a read answered OK, 32 data bits, lowest first, and then a parity bit are sampled on falling edges. `rsp_rdata` returns the word. `rsp_perr` is 1 exactly when the XOR of the 33 sampled bits is 1.
- R9: A read not answered OK has no data phase, and it returns `rsp_rdata`=0 and `rsp_perr`=0.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `rsp_ack`, `rsp_rdata` and `rsp_perr` hold steady.
- R11: A packet without a host data phase ends with one full period of release after its last sample. The line then returns to driven-low and the packet ends with no further clock edges. A packet with data takes 45 rising edges; one without takes 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command will be taken |
| cmd_apndp | input | 1 | 1 = access port, 0 = debug port |
| cmd_rnw | input | 1 | 1 = read, 0 = write |
| cmd_addr | input | 2 | Register index (address bits 3:2) |
| cmd_wdata | input | 32 | Word to write |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Result consumed |
| rsp_ack | output | 3 | Acknowledge code received |
| rsp_rdata | output | 32 | Word read |
| rsp_perr | output | 1 | Read parity mismatch |
| busy | output | 1 | Packet or result pending |
| swclk | output | 1 | Serial clock |
| swdio_o | output | 1 | Data line value driven by the host |
| swdio_oe | output | 1 | Host drives the data line |
| swdio_i | input | 1 | Data line value seen by the host |

## Verification
The assertions check, on every cycle, the properties that hold at any moment: the clock stays low when idle, its half period is steady, host-driven bits and enable rises fall on falling clock edges, the idle line is driven low, results stay frozen under back-pressure, and a parity error comes only with an OK read. Only the bench scenarios, with a target model answering on rising edges, can show the packet contents. These are the request bit order and parity, where the turnarounds fall, which acknowledge codes open a data phase, the data and parity bits in each direction, and the number of clock edges per packet.

// File: rtl/swd_host_pkg.sv
package swd_host_pkg;

  localparam logic [2:0] ACK_OK    = 3'b001;
  localparam logic [2:0] ACK_WAIT  = 3'b010;
  localparam logic [2:0] ACK_FAULT = 3'b100;
  localparam logic [2:0] ACK_NONE  = 3'b111;

  localparam int HDR_BITS = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_ACK,
    ST_TRN_W,
    ST_WDAT,
    ST_RDAT,
    ST_TRN_R,
    ST_DONE
  } seq_state_t;

  // Request byte, bit 0 leaves first.
  function automatic logic [HDR_BITS-1:0] build_request(input logic port_ap,
                                                        input logic is_read,
                                                        input logic [1:0] idx);
    logic par;
    par = port_ap ^ is_read ^ idx[0] ^ idx[1];
    return {1'b1, 1'b0, par, idx[1], idx[0], is_read, port_ap, 1'b1};
  endfunction

  // Codes after which a write still carries its data phase.
  function automatic logic write_phase_due(input logic [2:0] code);
    return (code == ACK_OK) || (code == ACK_WAIT) || (code == ACK_FAULT);
  endfunction

endpackage

// File: rtl/swd_clk_gen.sv
module swd_clk_gen #(
  parameter int CLK_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic swclk,
  output logic fall_ev
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

  logic [DIV_W-1:0] cnt;
  logic             wrap;

  assign wrap    = run && (cnt == DIV_LAST);
  assign fall_ev = wrap && swclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      swclk <= 1'b0;
    end else if (!run) begin
      cnt   <= '0;
      swclk <= 1'b0;
    end else if (wrap) begin
      cnt   <= '0;
      swclk <= ~swclk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/swd_seq.sv
module swd_seq
  import swd_host_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall_ev,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_apndp,
  input  logic              cmd_rnw,
  input  logic [1:0]        cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [2:0]        rsp_ack,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_perr,
  output logic              busy,
  output logic              run,
  output logic              swdio_o,
  output logic              swdio_oe,
  input  logic              swdio_i
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] DATA_END = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] HDR_END  = CNT_W'(HDR_BITS - 1);
  localparam logic [CNT_W-1:0] ACK_END  = CNT_W'(2);

  seq_state_t          state;
  logic [CNT_W-1:0]    bcnt;
  logic [HDR_BITS-1:0] hdr_sr;
  logic [DATA_W:0]     wsr;
  logic [DATA_W-1:0]   rsr;
  logic [1:0]          ack_sr;
  logic [2:0]          ack_now;
  logic                rnw_q;
  logic                par_acc;
  logic [HDR_BITS-1:0] req_word;

  assign req_word  = build_request(cmd_apndp, cmd_rnw, cmd_addr);
  assign ack_now   = {swdio_i, ack_sr};
  assign cmd_ready = (state == ST_IDLE);
  assign rsp_valid = (state == ST_DONE);
  assign busy      = (state != ST_IDLE);
  assign run       = (state != ST_IDLE) && (state != ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bcnt      <= '0;
      hdr_sr    <= '0;
      wsr       <= '0;
      rsr       <= '0;
      ack_sr    <= '0;
      rnw_q     <= 1'b0;
      par_acc   <= 1'b0;
      rsp_ack   <= '0;
      rsp_rdata <= '0;
      rsp_perr  <= 1'b0;
      swdio_o   <= 1'b0;
      swdio_oe  <= 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (cmd_valid) begin
            state     <= ST_HDR;
            bcnt      <= '0;
            hdr_sr    <= {1'b0, req_word[HDR_BITS-1:1]};
            wsr       <= {^cmd_wdata, cmd_wdata};
            rnw_q     <= cmd_rnw;
            par_acc   <= 1'b0;
            rsp_ack   <= '0;
            rsp_rdata <= '0;
            rsp_perr  <= 1'b0;
            swdio_o   <= req_word[0];
            swdio_oe  <= 1'b1;
          end
        end
        ST_HDR: begin
          if (fall_ev) begin
            if (bcnt == HDR_END) begin
              state    <= ST_ACK;
              bcnt     <= '0;
              swdio_oe <= 1'b0;
              swdio_o  <= 1'b0;
            end else begin
              swdio_o <= hdr_sr[0];
              hdr_sr  <= hdr_sr >> 1;
              bcnt    <= bcnt + 1'b1;
            end
          end
        end
        ST_ACK: begin
          if (fall_ev) begin
            ack_sr <= {swdio_i, ack_sr[1]};
            bcnt   <= bcnt + 1'b1;
            if (bcnt == ACK_END) begin
              rsp_ack <= ack_now;
              bcnt    <= '0;
              if (rnw_q && ack_now == ACK_OK)             state <= ST_RDAT;
              else if (!rnw_q && write_phase_due(ack_now)) state <= ST_TRN_W;
              else                                         state <= ST_TRN_R;
            end
          end
        end
        ST_TRN_W: begin
          if (fall_ev) begin
            state    <= ST_WDAT;
            bcnt     <= '0;
            swdio_oe <= 1'b1;
            swdio_o  <= wsr[0];
            wsr      <= wsr >> 1;
          end
        end
        ST_WDAT: begin
          if (fall_ev) begin
            if (bcnt == DATA_END) begin
              state   <= ST_DONE;
              swdio_o <= 1'b0;
            end else begin
              swdio_o <= wsr[0];
              wsr     <= wsr >> 1;
              bcnt    <= bcnt + 1'b1;
            end
          end
        end
        ST_RDAT: begin
          if (fall_ev) begin
            if (bcnt == DATA_END) begin
              rsp_rdata <= rsr;
              rsp_perr  <= par_acc ^ swdio_i;
              state     <= ST_TRN_R;
            end else begin
              rsr     <= {swdio_i, rsr[DATA_W-1:1]};
              par_acc <= par_acc ^ swdio_i;
              bcnt    <= bcnt + 1'b1;
            end
          end
        end
        ST_TRN_R: begin
          if (fall_ev) begin
            state    <= ST_DONE;
            swdio_oe <= 1'b1;
            swdio_o  <= 1'b0;
          end
        end
        ST_DONE: begin
          if (rsp_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/swd_host_engine.sv
module swd_host_engine #(
  parameter int CLK_DIV = 2,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_apndp,
  input  logic              cmd_rnw,
  input  logic [1:0]        cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [2:0]        rsp_ack,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_perr,
  output logic              busy,
  output logic              swclk,
  output logic              swdio_o,
  output logic              swdio_oe,
  input  logic              swdio_i
);
  logic run;
  logic fall_ev;

  swd_clk_gen #(.CLK_DIV(CLK_DIV)) clk_gen_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .swclk   (swclk),
    .fall_ev (fall_ev)
  );

  swd_seq #(.DATA_W(DATA_W)) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .fall_ev   (fall_ev),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_apndp (cmd_apndp),
    .cmd_rnw   (cmd_rnw),
    .cmd_addr  (cmd_addr),
    .cmd_wdata (cmd_wdata),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_ack   (rsp_ack),
    .rsp_rdata (rsp_rdata),
    .rsp_perr  (rsp_perr),
    .busy      (busy),
    .run       (run),
    .swdio_o   (swdio_o),
    .swdio_oe  (swdio_oe),
    .swdio_i   (swdio_i)
  );
endmodule

// File: rtl/swd_host_engine_chk.sv
module swd_host_engine_chk #(
  parameter int CLK_DIV = 2,
  parameter int DATA_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [2:0]        rsp_ack,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_perr,
  input logic              busy,
  input logic              swclk,
  input logic              swdio_o,
  input logic              swdio_oe
);
  logic [15:0] hcnt;
  logic        swclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt    <= '0;
      swclk_q <= 1'b0;
    end else begin
      swclk_q <= swclk;
      if (!busy || swclk != swclk_q) hcnt <= '0;
      else hcnt <= hcnt + 1'b1;
    end
  end

  assert_ready_not_pending_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!rsp_valid && !swclk));

  assert_clk_low_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !swclk);

  assert_half_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && swclk != $past(swclk)) |-> (hcnt >= 16'(CLK_DIV - 1) && hcnt <= 16'(CLK_DIV)));

  assert_host_bit_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && swdio_oe && $past(swdio_oe) && swdio_o != $past(swdio_o))
      |-> $fell(swclk));

  assert_idle_line_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (swdio_oe && !swdio_o));

  assert_drive_starts_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $rose(swdio_oe)) |-> $fell(swclk));

  assert_perr_only_ok_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_perr) |-> (rsp_ack == 3'b001));

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_ack) && $stable(rsp_rdata) && $stable(rsp_perr)));
endmodule

bind swd_host_engine swd_host_engine_chk #(.CLK_DIV(CLK_DIV), .DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_ready (cmd_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_ack   (rsp_ack),
  .rsp_rdata (rsp_rdata),
  .rsp_perr  (rsp_perr),
  .busy      (busy),
  .swclk     (swclk),
  .swdio_o   (swdio_o),
  .swdio_oe  (swdio_oe)
);

// File: tb/swd_host_engine_tb_top.sv
`timescale 1ns/1ps
module swd_host_engine_tb_top;
  localparam int CLK_DIV = 2;
  localparam int NVEC    = 9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_apndp = 1'b0, cmd_rnw = 1'b0;
  logic [1:0]  cmd_addr = '0;
  logic [31:0] cmd_wdata = '0;
  logic        rsp_ready = 1'b0;
  logic        swdio_i = 1'b1;
  logic        cmd_ready, rsp_valid, rsp_perr, busy, swclk, swdio_o, swdio_oe;
  logic [2:0]  rsp_ack;
  logic [31:0] rsp_rdata;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  swd_host_engine #(.CLK_DIV(CLK_DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_apndp(cmd_apndp), .cmd_rnw(cmd_rnw), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata),
    .rsp_perr(rsp_perr), .busy(busy), .swclk(swclk), .swdio_o(swdio_o),
    .swdio_oe(swdio_oe), .swdio_i(swdio_i)
  );

  // {rnw, apndp, addr[1:0], wdata[31:0], ack[2:0], rdata[31:0], bad_parity}
  localparam logic [71:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 2'd0, 32'h12345678, 3'b001, 32'h0,        1'b0},
    {1'b1, 1'b1, 2'd3, 32'h0,        3'b001, 32'hDEADBEEF, 1'b0},
    {1'b1, 1'b0, 2'd1, 32'h0,        3'b001, 32'h00000007, 1'b1},
    {1'b1, 1'b1, 2'd2, 32'h0,        3'b010, 32'hA5A5A5A5, 1'b0},
    {1'b0, 1'b1, 2'd1, 32'hFFFFFFFF, 3'b010, 32'h0,        1'b0},
    {1'b0, 1'b0, 2'd2, 32'h80000001, 3'b100, 32'h0,        1'b0},
    {1'b0, 1'b1, 2'd3, 32'hCAFEF00D, 3'b111, 32'h0,        1'b0},
    {1'b1, 1'b0, 2'd0, 32'h0,        3'b011, 32'h5555AAAA, 1'b0},
    {1'b1, 1'b1, 2'd1, 32'h0,        3'b001, 32'h00000000, 1'b0}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_xfer(input logic rnw, input logic ap, input logic [1:0] addr,
                          input logic [31:0] wd, input logic [2:0] ack,
                          input logic [31:0] rd, input logic bad, input bit poke);
    logic [7:0]  hdr_cap = '0, hdr_exp;
    logic [32:0] wcap = '0;
    int          rises = 0;
    bit          oe_bad = 0;
    bit          with_data;
    time         t0 = 0, t1 = 0;
    logic        rpar;
    with_data = rnw ? (ack == 3'b001) : (ack == 3'b001 || ack == 3'b010 || ack == 3'b100);
    hdr_exp   = {1'b1, 1'b0, ap ^ rnw ^ addr[0] ^ addr[1], addr[1], addr[0], rnw, ap, 1'b1};
    rpar      = (^rd) ^ bad;

    @(negedge clk);
    check(cmd_ready === 1'b1, "R1", "ready before command", 32'(cmd_ready), 32'd1);
    cmd_valid = 1'b1; cmd_rnw = rnw; cmd_apndp = ap; cmd_addr = addr; cmd_wdata = wd;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_wdata = 32'h0BAD0BAD; cmd_rnw = ~rnw;
    forever begin
      @(posedge swclk or posedge rsp_valid);
      if (rsp_valid) break;
      if (rises == 0) t0 = $time;
      if (rises == 1) t1 = $time;
      if (rises < 8) begin
        hdr_cap[rises] = swdio_o;
        if (!swdio_oe) oe_bad = 1;
      end else if (!rnw && with_data && rises >= 12) begin
        if (!swdio_oe) oe_bad = 1;
        if (rises <= 44) wcap[rises-12] = swdio_o;
      end else if (swdio_oe) oe_bad = 1;
      if (rises >= 8 && rises <= 10) swdio_i = ack[rises-8];
      else if (rnw && with_data && rises >= 11 && rises <= 42) swdio_i = rd[rises-11];
      else if (rnw && with_data && rises == 43) swdio_i = rpar;
      else swdio_i = 1'b1;
      if (poke && rises == 3) begin
        #2;
        check(cmd_ready === 1'b0, "R1", "ready while busy", 32'(cmd_ready), 32'd0);
        cmd_valid = 1'b1; cmd_wdata = 32'h0; cmd_rnw = 1'b1;
      end
      if (poke && rises == 5) begin
        #2;
        cmd_valid = 1'b0;
      end
      rises++;
    end
    swdio_i = 1'b1;
    check(hdr_cap == hdr_exp, "R3", "request bits", 32'(hdr_cap), 32'(hdr_exp));
    check(t1 - t0 == 2 * CLK_DIV * 10, "R2", "clock period ns", 32'(t1 - t0), 32'(2 * CLK_DIV * 10));
    check(rises == (with_data ? 45 : 12), "R11", "rising edges per packet", 32'(rises),
          with_data ? 32'd45 : 32'd12);
    check(!oe_bad, "R5", "drive enable per phase (R6 turnaround)", 32'(oe_bad), 32'd0);
    if (!rnw && with_data) begin
      check(wcap[31:0] == wd, "R6", "write data bits", wcap[31:0], wd);
      check(wcap[32] == ^wd, "R7", "write parity bit", 32'(wcap[32]), 32'(^wd));
    end
    repeat (3) @(negedge clk);
    check(rsp_valid && !cmd_ready, "R10", "result held under back-pressure",
          32'({rsp_valid, cmd_ready}), 32'b10);
    check(rsp_ack == ack, "R5", "ack code", 32'(rsp_ack), 32'(ack));
    if (rnw && with_data) begin
      check(rsp_rdata == rd, "R8", "read word", rsp_rdata, rd);
      check(rsp_perr == bad, "R8", "read parity flag", 32'(rsp_perr), 32'(bad));
    end else if (rnw) begin
      check(rsp_rdata == 32'h0 && !rsp_perr, "R9", "skipped read result",
            rsp_rdata | 32'(rsp_perr), 32'h0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check(cmd_ready && !busy, "R1", "ready after consume", 32'({cmd_ready, busy}), 32'b10);
    check(swdio_oe && !swdio_o && !swclk, "R4", "idle line low, clock low",
          32'({swdio_oe, swdio_o, swclk}), 32'b100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(cmd_ready && !rsp_valid && !busy, "R1", "reset handshake",
          32'({cmd_ready, rsp_valid, busy}), 32'b100);
    check(!swclk && swdio_oe && !swdio_o, "R2", "reset pins (R4 line low)",
          32'({swclk, swdio_oe, swdio_o}), 32'b010);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!swclk && !busy, "R2", "no clock while idle", 32'({swclk, busy}), 32'b00);

    for (int i = 0; i < NVEC; i++) begin
      logic [71:0] v;
      v = VEC[i];
      run_xfer(v[71], v[70], v[69:68], v[67:36], v[35:33], v[32:1], v[0], 1'b0);
    end

    // Command offered mid-packet must not disturb the write in flight (R1).
    run_xfer(1'b0, 1'b1, 2'd2, 32'h3C3C00FF, 3'b001, 32'h0, 1'b0, 1'b1);
    // Back-to-back read with odd-weight word and good parity (R8).
    run_xfer(1'b1, 1'b0, 2'd3, 32'h00000001, 3'b001, 32'h00000001, 1'b0, 1'b0);
    // Read with FAULT: no data phase (R9).
    run_xfer(1'b1, 1'b0, 2'd1, 32'h0, 3'b100, 32'hFFFFFFFF, 1'b0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule